// File: doc/BRIEF.md
# Amplifier Power Mode Controller

This block sequences the operating modes of an audio amplifier. Four modes are visible to the host: Off, Sleep, Standby and Run. A fifth, transitional Muting mode sits between Run and Standby. The block receives already-decoded host commands: power-up, power-down, and activate with a mode argument. It also has an active-low reset pin. From the current mode it decides whether each command is accepted or rejected. From the same mode it gates the amplifier output, the mute request, the clock output, the timing generator, the audio activity detector and the permission to write configuration registers.

A move from Run to Standby never happens directly. The block first raises the mute request and waits for the audio path to report that mute is in effect. A programmable cycle limit bounds this wait. If the limit runs out, the block enters Standby anyway and records the event in a sticky flag that only reset clears.

The clock-output request comes from the configuration register file. In Standby it also decides whether the timing generator keeps running. In Sleep and Off the clock output is always forced low.

Top module: `amp_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 0 (Off). All enables, `cmd_ack`, `cmd_err` and `mute_tmo_flag` are 0, `mute_req` is 1, and commands presented during reset have no effect.
- R2: In Off only power-up is accepted, and it moves the block to Sleep. Every other command raises `cmd_err` and leaves the mode unchanged.
- R3: Commands are encoded as follows. `cmd_op`: 0 is power-up, 1 is power-down, 2 is activate, 3 is reserved and always rejected. `cmd_arg`: 0 is Run, 1 is Standby, 2 is Standby with activity watch, 3 is Sleep. `mode_o`: 0 is Off, 1 is Sleep, 2 is Standby, 3 is Run, 4 is Muting. Each command sampled at a clock edge gives exactly one one-cycle pulse on `cmd_ack` or on `cmd_err`, visible after that edge. A rejected command leaves the mode unchanged.
- R4: Sleep accepts power-down (to Off) and activate with Run, Standby or Standby-with-watch. It rejects activate with Sleep.
- R5: Run accepts power-down (to Off), activate-Sleep (straight to Sleep) and activate-Standby (to Muting). Other activate arguments are rejected.
- R6: Standby accepts power-down (to Off), activate-Run and activate-Sleep. Other activate arguments are rejected.
- R7: In Muting, an edge with `mute_done` high moves the block to Standby without setting `mute_tmo_flag`. `mute_done` wins over an expiry in the same cycle.
- R8: If `mute_done` stays low, Muting lasts max(`mute_limit`,1) cycles and then enters Standby. At that point `mute_tmo_flag` is set, and it stays set until reset.
- R9: In Muting every command is rejected with `cmd_err`.
- R10: `amp_en` is 1 only in Run. `mute_req` is 1 in every mode except Run.
- R11: `clko_en` equals `cfg_clko` in Run, Muting and Standby, and is 0 in Sleep and Off. `tgen_en` is 1 in Run and Muting, equals `cfg_clko` in Standby, and is 0 otherwise.
- R12: `reg_wr_ok` is 1 in Run, Muting and Standby, and 0 in Sleep and Off.
- R13: `aad_en` is 1 only while in a Standby that was entered from Sleep by activate with argument 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A decoded host command is present this cycle |
| cmd_op | input | 2 | Command opcode |
| cmd_arg | input | 2 | Activate argument |
| cfg_clko | input | 1 | Clock-output request from configuration |
| mute_done | input | 1 | Audio path reports mute in effect |
| mute_limit | input | TMO_W | Muting wait limit in cycles |
| mode_o | output | 3 | Current mode |
| cmd_ack | output | 1 | Command accepted pulse |
| cmd_err | output | 1 | Command rejected pulse |
| amp_en | output | 1 | Amplifier output enable |
| mute_req | output | 1 | Mute request |
| clko_en | output | 1 | Buffered clock-output enable |
| tgen_en | output | 1 | Timing generator enable |
| aad_en | output | 1 | Audio activity detector enable |
| reg_wr_ok | output | 1 | Register writes permitted |
| mute_tmo_flag | output | 1 | Sticky muting-timeout flag |

## Verification
The hardest situation to reach from the ports is the end of a Muting wait. To get there the stimulus must first walk Off → Sleep → Run and then issue activate-Standby. After that, `mute_done` must either stay low for exactly the limit or rise on the very cycle the limit expires. The random stimulus keeps `mute_limit` small (0 to 6) and raises `mute_done` only rarely. This makes timeouts, limit-zero exits and done-at-expiry collisions all frequent. A directed prefix drives one Run-to-Standby wait to a timeout with a limit of 3, and a bench model tracks each cycle spent waiting.

// File: rtl/amp_mode_pkg.sv
package amp_mode_pkg;

  typedef enum logic [2:0] {
    MD_OFF    = 3'd0,
    MD_SLEEP  = 3'd1,
    MD_STBY   = 3'd2,
    MD_RUN    = 3'd3,
    MD_MUTING = 3'd4
  } amp_mode_e;

  localparam logic [1:0] OP_POWER_UP   = 2'd0;
  localparam logic [1:0] OP_POWER_DOWN = 2'd1;
  localparam logic [1:0] OP_ACTIVATE   = 2'd2;

  localparam logic [1:0] ARG_RUN   = 2'd0;
  localparam logic [1:0] ARG_STBY  = 2'd1;
  localparam logic [1:0] ARG_WATCH = 2'd2;
  localparam logic [1:0] ARG_SLEEP = 2'd3;

  typedef struct packed {
    logic      legal;
    amp_mode_e target;
    logic      watch;
  } cmd_verdict_t;

  // Legality table: which command moves which mode where.
  function automatic cmd_verdict_t judge_cmd(amp_mode_e cur, logic [1:0] op,
                                             logic [1:0] arg);
    cmd_verdict_t v;
    v.legal  = 1'b0;
    v.target = cur;
    v.watch  = 1'b0;
    unique case (cur)
      MD_OFF: begin
        if (op == OP_POWER_UP) begin
          v.legal = 1'b1; v.target = MD_SLEEP;
        end
      end
      MD_SLEEP: begin
        if (op == OP_POWER_DOWN) begin
          v.legal = 1'b1; v.target = MD_OFF;
        end else if (op == OP_ACTIVATE) begin
          if (arg == ARG_RUN) begin
            v.legal = 1'b1; v.target = MD_RUN;
          end else if (arg == ARG_STBY) begin
            v.legal = 1'b1; v.target = MD_STBY;
          end else if (arg == ARG_WATCH) begin
            v.legal = 1'b1; v.target = MD_STBY; v.watch = 1'b1;
          end
        end
      end
      MD_STBY: begin
        if (op == OP_POWER_DOWN) begin
          v.legal = 1'b1; v.target = MD_OFF;
        end else if (op == OP_ACTIVATE && arg == ARG_RUN) begin
          v.legal = 1'b1; v.target = MD_RUN;
        end else if (op == OP_ACTIVATE && arg == ARG_SLEEP) begin
          v.legal = 1'b1; v.target = MD_SLEEP;
        end
      end
      MD_RUN: begin
        if (op == OP_POWER_DOWN) begin
          v.legal = 1'b1; v.target = MD_OFF;
        end else if (op == OP_ACTIVATE && arg == ARG_SLEEP) begin
          v.legal = 1'b1; v.target = MD_SLEEP;
        end else if (op == OP_ACTIVATE && arg == ARG_STBY) begin
          v.legal = 1'b1; v.target = MD_MUTING;
        end
      end
      default: v.legal = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/amp_cmd_judge.sv
module amp_cmd_judge
  import amp_mode_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  amp_mode_e    cur_mode,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd_op,
  input  logic [1:0]   cmd_arg,
  output cmd_verdict_t verdict
);

  always_comb verdict = judge_cmd(cur_mode, cmd_op, cmd_arg);

  // R5: only Run may start a mute handshake
  p_mute_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && verdict.legal && verdict.target == MD_MUTING) |-> cur_mode == MD_RUN);

  // R2: Off never grants anything but power-up
  p_off_only_pup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MD_OFF && cmd_op != OP_POWER_UP) |-> !verdict.legal);

endmodule

// File: rtl/amp_mute_timer.sv
module amp_mute_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             done,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  localparam int CW = TMO_W + 1;

  logic [TMO_W-1:0] cnt_q;

  // True when the cycle now ending is the last one allowed.
  function automatic logic limit_hit(logic [TMO_W-1:0] c, logic [TMO_W-1:0] l);
    logic [CW-1:0] used;
    used = {1'b0, c} + CW'(1);
    return used >= {1'b0, l};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + TMO_W'(1);
    else          cnt_q <= '0;
  end

  assign expire = run && !done && limit_hit(cnt_q, limit);

  // R8: an expiry always ends the wait
  p_expire_exits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run);

  // R7: mute-done always ends the wait
  p_done_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done) |=> !run);

endmodule

// File: rtl/amp_out_gate.sv
module amp_out_gate
  import amp_mode_pkg::*;
(
  input  amp_mode_e mode,
  input  logic      cfg_clko,
  output logic      amp_en,
  output logic      mute_req,
  output logic      clko_en,
  output logic      tgen_en,
  output logic      reg_wr_ok
);

  logic powered;  // Run, Muting or Standby

  always_comb begin
    powered   = (mode == MD_RUN) || (mode == MD_MUTING) || (mode == MD_STBY);
    amp_en    = (mode == MD_RUN);
    mute_req  = (mode != MD_RUN);
    clko_en   = powered && cfg_clko;
    tgen_en   = (mode == MD_RUN) || (mode == MD_MUTING) ||
                ((mode == MD_STBY) && cfg_clko);
    reg_wr_ok = powered;
  end

endmodule

// File: rtl/amp_mode_ctrl.sv
module amp_mode_ctrl
  import amp_mode_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [1:0]       cmd_arg,
  input  logic             cfg_clko,
  input  logic             mute_done,
  input  logic [TMO_W-1:0] mute_limit,
  output logic [2:0]       mode_o,
  output logic             cmd_ack,
  output logic             cmd_err,
  output logic             amp_en,
  output logic             mute_req,
  output logic             clko_en,
  output logic             tgen_en,
  output logic             aad_en,
  output logic             reg_wr_ok,
  output logic             mute_tmo_flag
);

  amp_mode_e    mode_q;
  cmd_verdict_t verdict;
  logic         muting;
  logic         mute_expire;
  logic         watch_q, sticky_q, ack_q, err_q;

  assign muting = (mode_q == MD_MUTING);

  amp_cmd_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_mode  (mode_q),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .verdict   (verdict)
  );

  amp_mute_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (muting),
    .done   (mute_done),
    .limit  (mute_limit),
    .expire (mute_expire)
  );

  amp_out_gate u_gate (
    .mode      (mode_q),
    .cfg_clko  (cfg_clko),
    .amp_en    (amp_en),
    .mute_req  (mute_req),
    .clko_en   (clko_en),
    .tgen_en   (tgen_en),
    .reg_wr_ok (reg_wr_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_OFF;
      watch_q  <= 1'b0;
      sticky_q <= 1'b0;
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      if (muting) begin
        if (cmd_valid) err_q <= 1'b1;
        if (mute_done || mute_expire) mode_q <= MD_STBY;
        if (mute_expire) sticky_q <= 1'b1;
      end else if (cmd_valid) begin
        if (verdict.legal) begin
          mode_q  <= verdict.target;
          watch_q <= verdict.watch;
          ack_q   <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign mode_o        = mode_q;
  assign cmd_ack       = ack_q;
  assign cmd_err       = err_q;
  assign aad_en        = watch_q && (mode_q == MD_STBY);
  assign mute_tmo_flag = sticky_q;

  // R5: Run never reaches Standby without passing through Muting
  p_no_direct_stby_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RUN) |=> (mode_q != MD_STBY));

  // R3: at most one verdict pulse per command
  p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ack && cmd_err));

  // R9: commands during Muting are refused
  p_muting_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (muting && cmd_valid) |=> cmd_err);

  // R8: the timeout flag never clears outside reset
  p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mute_tmo_flag |=> mute_tmo_flag);

  // R13: the activity detector only runs in Standby
  p_watch_in_stby_r13: assert property (@(posedge clk) disable iff (!rst_n)
    aad_en |-> (mode_o == 3'd2));

  // R11: Sleep keeps clock output and timing generator off
  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1) |-> (!clko_en && !tgen_en));

endmodule

// File: tb/tb_amp_mode_ctrl.sv
`timescale 1ns/1ps
module tb_amp_mode_ctrl;

  localparam int TMO_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic [1:0]       cmd_arg = 2'd0;
  logic             cfg_clko = 1'b0;
  logic             mute_done = 1'b0;
  logic [TMO_W-1:0] mute_limit = '0;
  logic [2:0]       mode_o;
  logic cmd_ack, cmd_err, amp_en, mute_req, clko_en, tgen_en, aad_en, reg_wr_ok, mute_tmo_flag;

  amp_mode_ctrl #(.TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cfg_clko(cfg_clko), .mute_done(mute_done),
    .mute_limit(mute_limit), .mode_o(mode_o), .cmd_ack(cmd_ack),
    .cmd_err(cmd_err), .amp_en(amp_en), .mute_req(mute_req),
    .clko_en(clko_en), .tgen_en(tgen_en), .aad_en(aad_en),
    .reg_wr_ok(reg_wr_ok), .mute_tmo_flag(mute_tmo_flag)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  int m_mode = 0, m_cnt = 0;
  bit m_watch = 0, m_sticky = 0, m_ack = 0, m_err = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Mode reached by a command, or -1 if it is refused.
  function automatic int next_of(int m, int op, int arg);
    case (m)
      0: return (op == 0) ? 1 : -1;
      1: if (op == 1) return 0;
         else if (op == 2 && arg == 0) return 3;
         else if (op == 2 && (arg == 1 || arg == 2)) return 2;
         else return -1;
      2: if (op == 1) return 0;
         else if (op == 2 && arg == 0) return 3;
         else if (op == 2 && arg == 3) return 1;
         else return -1;
      3: if (op == 1) return 0;
         else if (op == 2 && arg == 3) return 1;
         else if (op == 2 && arg == 1) return 4;
         else return -1;
      default: return -1;
    endcase
  endfunction

  task automatic check_all();
    bit pw;
    pw = (m_mode == 2 || m_mode == 3 || m_mode == 4);
    chk("R2 R4 R5 R6 R7 R8 R9", "mode", int'(mode_o), m_mode);
    chk("R3", "cmd_ack", int'(cmd_ack), int'(m_ack));
    chk("R3", "cmd_err", int'(cmd_err), int'(m_err));
    chk("R10", "amp_en", int'(amp_en), int'(m_mode == 3));
    chk("R10", "mute_req", int'(mute_req), int'(m_mode != 3));
    chk("R11", "clko_en", int'(clko_en), int'(pw && cfg_clko));
    chk("R11", "tgen_en", int'(tgen_en),
        int'(m_mode == 3 || m_mode == 4 || (m_mode == 2 && cfg_clko)));
    chk("R12", "reg_wr_ok", int'(reg_wr_ok), int'(pw));
    chk("R13", "aad_en", int'(aad_en), int'(m_watch && m_mode == 2));
    chk("R8", "mute_tmo_flag", int'(mute_tmo_flag), int'(m_sticky));
  endtask

  // Check the present state, then drive one cycle and advance the model.
  task automatic cyc(bit rn, bit v, int op, int arg, bit d, int lim, bit cfg);
    int nx;
    @(negedge clk);
    check_all();
    rst_n = rn; cmd_valid = v; cmd_op = 2'(op); cmd_arg = 2'(arg);
    mute_done = d; mute_limit = TMO_W'(lim); cfg_clko = cfg;
    if (!rn) begin
      m_mode = 0; m_watch = 0; m_sticky = 0; m_ack = 0; m_err = 0; m_cnt = 0;
      return;
    end
    m_ack = 0; m_err = 0;
    if (m_mode == 4) begin
      if (v) m_err = 1;
      if (d) m_mode = 2;
      else if (m_cnt + 1 >= lim) begin m_mode = 2; m_sticky = 1; end
      else m_cnt++;
    end else if (v) begin
      nx = next_of(m_mode, op, arg);
      if (nx >= 0) begin
        m_ack = 1;
        m_watch = (m_mode == 1 && op == 2 && arg == 2);
        m_mode = nx;
        m_cnt = 0;
      end else m_err = 1;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    // R1: commands during reset are ignored
    cyc(0, 1, 0, 0, 0, 3, 1);
    cyc(0, 1, 2, 0, 0, 3, 1);
    cyc(1, 1, 2, 0, 0, 3, 1);   // R2: activate refused in Off
    cyc(1, 1, 0, 0, 0, 3, 1);   // power-up to Sleep
    cyc(1, 1, 2, 3, 0, 3, 1);   // R4: activate-Sleep refused
    cyc(1, 1, 2, 0, 0, 3, 0);   // to Run
    cyc(1, 1, 2, 1, 0, 3, 0);   // R5: to Muting
    cyc(1, 1, 0, 0, 0, 3, 0);   // R9: refused while muting
    cyc(1, 0, 0, 0, 0, 3, 0);
    cyc(1, 0, 0, 0, 0, 3, 0);   // R8: timeout after 3 cycles
    cyc(1, 1, 2, 0, 0, 3, 1);   // R6: Standby to Run
    cyc(1, 1, 2, 1, 1, 0, 1);   // to Muting, limit 0
    cyc(1, 0, 0, 0, 1, 0, 1);   // R7: done wins over expiry
    cyc(1, 1, 3, 0, 0, 0, 1);   // reserved op refused
    cyc(0, 0, 0, 0, 0, 0, 0);   // R1: reset clears sticky
    cyc(1, 1, 0, 0, 0, 0, 1);
    cyc(1, 1, 2, 2, 0, 0, 1);   // R13: watch Standby
    cyc(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6000; i++) begin
      bit rn;
      rn = ($urandom_range(0, 499) != 0);
      cyc(rn, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
          $urandom_range(0, 3), $urandom_range(0, 5) == 0,
          $urandom_range(0, 6), (i % 37) < 20);
    end
    @(negedge clk);
    check_all();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule